// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block sits between a processor port and a slower memory. It holds 4096 lines of four 32-bit words each, and every line can live in exactly one slot. A load that finds its line in the cache is answered with no memory traffic. A load that misses stalls the requester. The block then asks memory for the whole line, collects the four words in order, installs them, and returns the word that was asked for.

Stores are write-through. Each store is queued in a four-entry posted buffer that drains to memory in the background, so the requester only waits when the buffer is full. A store that hits also updates the cached copy. A store that misses leaves the cache alone. Loads search the pending stores, so data that has not yet reached memory is never lost. Draining pauses while a line is being refilled, and a refilled word takes the newest queued store to that word in place of the memory value.

Top module: `wt_cache`

## Requirements
- R1: A byte address splits as tag = bits 31:16, line index = bits 15:4, word-in-line = bits 3:2 and byte = bits 1:0. A load hits only when the line at its index is valid and holds its tag, so two addresses with equal index and different tags evict each other.
- R2: After reset no line is valid: `cpu_stall`, `cpu_done`, `mem_rd_req` and `mem_wr_valid` are low, and the first load to any address misses.
- R3: A load hit raises `cpu_done` two cycles after the request is accepted, with `cpu_stall` high for exactly the one cycle between, and it issues no memory read.
- R4: A load miss raises `mem_rd_req` for one cycle with `mem_rd_addr` line-aligned (bits 3:0 zero). It accepts four `mem_rd_valid` beats that carry word-in-line 0, 1, 2, 3 in that order, and raises `cpu_done` with the requested word in the cycle after the fourth beat. Later loads to any word of that line hit.
- R5: Every store appears exactly once on the memory write port, in issue order. The write address is the store address with bits 1:0 forced to zero, because the byte offset is ignored.
- R6: A store that hits updates the cached word, so a later load hit returns it. A store that misses allocates nothing, so a later load to that line misses. A store never causes a memory read.
- R7: The store buffer holds four entries. With fewer than four pending, a store finishes in two cycles. With four pending, the store stays stalled until an entry drains.
- R8: A load returns the newest queued store to the same word address when one exists. During a refill, each incoming word is replaced by the newest queued store to that word before it is installed.
- R9: From the cycle `mem_rd_req` rises until the fourth refill beat, `mem_wr_valid` is low.
- R10: `cpu_stall` is low exactly when a request can be accepted. `cpu_done` is a one-cycle pulse and is seen with `cpu_stall` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request, accepted in a cycle where `cpu_stall` is low |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_stall | output | 1 | Busy; no request accepted |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load result, valid with `cpu_done` |
| mem_rd_req | output | 1 | One-cycle line read request |
| mem_rd_addr | output | 32 | Line-aligned byte address of the read |
| mem_rd_valid | input | 1 | Refill beat present |
| mem_rd_data | input | 32 | Refill word |
| mem_wr_valid | output | 1 | Write offered; may drop before acceptance |
| mem_wr_ready | input | 1 | Memory takes the write when both are high |
| mem_wr_addr | output | 32 | Word-aligned write address |
| mem_wr_data | output | 32 | Write data |

## Verification
Two functions can fall in the same cycle: a refill beat arriving and a queued store waiting for the same word. The bench provokes this by holding `mem_wr_ready` low, queueing stores to a line that is not cached, and then loading from that line. The requested word and the neighbouring words must come back as the queued values, not the stale memory image. The push of a new store and the drain of the oldest entry also coincide while random ready patterns run. These cases are judged by matching every accepted memory write, in order, against a behavioural queue, and every load result against a per-word map of the last stored values.

// File: rtl/wt_cache_pkg.sv
package wt_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_FILL = 2'd2
  } cache_state_t;
endpackage

// File: rtl/wt_sdp_ram.sv
// Simple dual-port memory, registered read, written for block RAM inference.
module wt_sdp_ram #(
  parameter int AW = 12,
  parameter int DW = 128
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/wt_write_buffer.sv
// Posted store FIFO with a newest-first associative search.
module wt_write_buffer #(
  parameter int DEPTH = 4,
  parameter int AW    = 30,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic          full,
  output logic          out_valid,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data,
  input  logic [AW-1:0] snoop_addr,
  output logic          snoop_hit,
  output logic [DW-1:0] snoop_data
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [AW-1:0]  addr_mem [DEPTH];
  logic [DW-1:0]  data_mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [PTR_W:0]   count;

  assign full      = (count == (PTR_W+1)'(DEPTH));
  assign out_valid = (count != '0);
  assign out_addr  = addr_mem[rd_ptr];
  assign out_data  = data_mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) begin
      addr_mem[wr_ptr] <= push_addr;
      data_mem[wr_ptr] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + (PTR_W+1)'(push) - (PTR_W+1)'(pop);
    end
  end

  // Walk oldest to newest; a later match overrides an earlier one.
  always_comb begin
    logic [PTR_W-1:0] pos;
    snoop_hit  = 1'b0;
    snoop_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      pos = rd_ptr + PTR_W'(i);
      if ((PTR_W+1)'(i) < count && addr_mem[pos] == snoop_addr) begin
        snoop_hit  = 1'b1;
        snoop_data = data_mem[pos];
      end
    end
  end
endmodule

// File: rtl/wt_cache.sv
module wt_cache
  import wt_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int INDEX_W    = 12,
  parameter int WB_DEPTH   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_stall,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data
);
  localparam int BYTE_W  = $clog2(DATA_W / 8);
  localparam int OFF_W   = $clog2(LINE_WORDS);
  localparam int WADDR_W = ADDR_W - BYTE_W;
  localparam int TAG_W   = WADDR_W - OFF_W - INDEX_W;
  localparam int LINE_W  = DATA_W * LINE_WORDS;
  localparam int LINES   = 1 << INDEX_W;

  cache_state_t state_q;
  logic [WADDR_W-1:0] addr_q;
  logic               we_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [LINES-1:0]   valid_vec;
  logic               valid_rd;
  logic [OFF_W-1:0]   beat_q;
  logic [LINE_W-1:0]  fill_line_q;

  logic [INDEX_W-1:0] cpu_idx, idx_q, rd_idx;
  logic [TAG_W-1:0]   tag_q, tag_rd;
  logic [OFF_W-1:0]   woff_q;
  logic [LINE_W-1:0]  line_rd, line_wdata, store_merge, fill_next;
  logic               line_we, tag_we, hit, last_beat;

  logic               wb_push, wb_pop, wb_full, wb_valid, snoop_hit;
  logic [WADDR_W-1:0] wb_addr, snoop_addr;
  logic [DATA_W-1:0]  wb_data, snoop_data, beat_word;

  wire unused_byte_bits = ^cpu_addr[BYTE_W-1:0];

  assign cpu_idx = cpu_addr[BYTE_W+OFF_W +: INDEX_W];
  assign idx_q   = addr_q[OFF_W +: INDEX_W];
  assign tag_q   = addr_q[WADDR_W-1 -: TAG_W];
  assign woff_q  = addr_q[OFF_W-1:0];
  assign rd_idx  = (state_q == ST_IDLE) ? cpu_idx : idx_q;

  assign hit       = valid_rd && (tag_rd == tag_q);
  assign last_beat = (beat_q == OFF_W'(LINE_WORDS - 1));
  assign cpu_stall = (state_q != ST_IDLE);

  // Buffer search: the requested word on lookup, the arriving word on refill.
  assign snoop_addr = (state_q == ST_FILL) ? {addr_q[WADDR_W-1:OFF_W], beat_q} : addr_q;
  assign beat_word  = snoop_hit ? snoop_data : mem_rd_data;

  always_comb begin
    store_merge = line_rd;
    store_merge[woff_q*DATA_W +: DATA_W] = wdata_q;
    fill_next = fill_line_q;
    fill_next[beat_q*DATA_W +: DATA_W] = beat_word;
  end

  assign wb_push    = (state_q == ST_LOOK) && we_q && !wb_full;
  assign line_we    = (wb_push && hit) || (tag_we);
  assign tag_we     = (state_q == ST_FILL) && mem_rd_valid && last_beat;
  assign line_wdata = (state_q == ST_FILL) ? fill_next : store_merge;

  assign mem_wr_valid = wb_valid && (state_q != ST_FILL);
  assign wb_pop       = mem_wr_valid && mem_wr_ready;
  assign mem_wr_addr  = {wb_addr, {BYTE_W{1'b0}}};
  assign mem_wr_data  = wb_data;
  assign mem_rd_addr  = {addr_q[WADDR_W-1:OFF_W], {(OFF_W+BYTE_W){1'b0}}};

  wt_sdp_ram #(.AW(INDEX_W), .DW(LINE_W)) u_lines (
    .clk(clk), .we(line_we), .waddr(idx_q), .wdata(line_wdata),
    .raddr(rd_idx), .rdata(line_rd)
  );

  wt_sdp_ram #(.AW(INDEX_W), .DW(TAG_W)) u_tags (
    .clk(clk), .we(tag_we), .waddr(idx_q), .wdata(tag_q),
    .raddr(rd_idx), .rdata(tag_rd)
  );

  wt_write_buffer #(.DEPTH(WB_DEPTH), .AW(WADDR_W), .DW(DATA_W)) u_wbuf (
    .clk(clk), .rst(rst),
    .push(wb_push), .push_addr(addr_q), .push_data(wdata_q),
    .pop(wb_pop), .full(wb_full),
    .out_valid(wb_valid), .out_addr(wb_addr), .out_data(wb_data),
    .snoop_addr(snoop_addr), .snoop_hit(snoop_hit), .snoop_data(snoop_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cpu_done    <= 1'b0;
      mem_rd_req  <= 1'b0;
      valid_vec   <= '0;
      valid_rd    <= 1'b0;
      beat_q      <= '0;
      addr_q      <= '0;
      we_q        <= 1'b0;
      wdata_q     <= '0;
      cpu_rdata   <= '0;
      fill_line_q <= '0;
    end else begin
      cpu_done   <= 1'b0;
      mem_rd_req <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (cpu_req) begin
            addr_q   <= cpu_addr[ADDR_W-1:BYTE_W];
            we_q     <= cpu_we;
            wdata_q  <= cpu_wdata;
            valid_rd <= valid_vec[cpu_idx];
            state_q  <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (we_q) begin
            if (!wb_full) begin
              cpu_done <= 1'b1;
              state_q  <= ST_IDLE;
            end
          end else if (hit) begin
            cpu_rdata <= snoop_hit ? snoop_data : line_rd[woff_q*DATA_W +: DATA_W];
            cpu_done  <= 1'b1;
            state_q   <= ST_IDLE;
          end else begin
            mem_rd_req <= 1'b1;
            beat_q     <= '0;
            state_q    <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_rd_valid) begin
            fill_line_q <= fill_next;
            beat_q      <= beat_q + 1'b1;
            if (beat_q == woff_q) cpu_rdata <= beat_word;
            if (last_beat) begin
              valid_vec[idx_q] <= 1'b1;
              cpu_done         <= 1'b1;
              state_q          <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wt_cache_chk.sv
module wt_cache_chk #(
  parameter int LINE_WORDS = 4
) (
  input logic        clk,
  input logic        rst,
  input logic        cpu_req,
  input logic        cpu_stall,
  input logic        cpu_done,
  input logic        mem_rd_req,
  input logic [31:0] mem_rd_addr,
  input logic        mem_rd_valid,
  input logic        mem_wr_valid,
  input logic [31:0] mem_wr_addr
);
  logic [7:0] beats_left;

  always_ff @(posedge clk) begin
    if (rst) beats_left <= '0;
    else if (mem_rd_req) beats_left <= 8'(LINE_WORDS);
    else if (mem_rd_valid && beats_left != '0) beats_left <= beats_left - 1'b1;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done); // R10
  AST_DONE_UNSTALLED: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> !cpu_stall); // R10
  AST_ACCEPT_STALLS: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_stall) |=> cpu_stall); // R10
  AST_RDREQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |=> !mem_rd_req); // R4
  AST_RDREQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> (mem_rd_addr[3:0] == 4'd0)); // R4
  AST_WR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> (mem_wr_addr[1:0] == 2'd0)); // R5
  AST_NO_DRAIN_IN_FILL: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req || beats_left != '0) |-> !mem_wr_valid); // R9
endmodule

bind wt_cache wt_cache_chk #(.LINE_WORDS(LINE_WORDS)) u_chk (.*);

// File: tb/wt_cache_bench.sv
`timescale 1ns/1ps
module wt_cache_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_stall, cpu_done, mem_rd_req, mem_wr_valid;
  logic [31:0] cpu_rdata, mem_rd_addr, mem_wr_addr, mem_wr_data;
  logic        mem_rd_valid = 1'b0, mem_wr_ready = 1'b0;
  logic [31:0] mem_rd_data = '0;

  always #2.5 clk = ~clk;

  wt_cache u_wt_cache (.*);

  int total = 0, fails = 0, cyc = 0, rd_count = 0, last_beat_cyc = 0, last_lat = 0;
  int beats_out = 0, delay = 0;
  bit wr_ctl = 1'b1, done_flag = 1'b0;
  logic [15:0] rng = 16'hACE1;
  logic [31:0] fb [4];
  logic [31:0] mem_img [logic [29:0]];
  logic [31:0] ref_val [logic [29:0]];
  logic [15:0] ref_tag [logic [11:0]];
  logic [31:0] exp_wq_a [$];
  logic [31:0] exp_wq_d [$];

  function automatic logic [31:0] init_word(logic [29:0] w);
    return 32'({2'b0, w} * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] mem_get(logic [29:0] w);
    return mem_img.exists(w) ? mem_img[w] : init_word(w);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Behavioural memory: takes writes, answers line reads after two idle cycles.
  always @(negedge clk) begin
    rng = {rng[14:0], rng[15] ^ rng[13] ^ rng[12] ^ rng[10]};
    mem_wr_ready = wr_ctl && (rng[0] | rng[3]);
    if (!rst) begin
      if (beats_out > 0) chk(!mem_wr_valid, "R9", "write offered during refill", 32'(mem_wr_valid), 0);
      if (mem_wr_valid && mem_wr_ready) begin
        if (exp_wq_a.size() == 0) chk(0, "R5", "unexpected write", mem_wr_addr, 0);
        else begin
          chk(mem_wr_addr == exp_wq_a[0], "R5", "write address", mem_wr_addr, exp_wq_a[0]);
          chk(mem_wr_data == exp_wq_d[0], "R5", "write data", mem_wr_data, exp_wq_d[0]);
          void'(exp_wq_a.pop_front());
          void'(exp_wq_d.pop_front());
        end
        mem_img[mem_wr_addr[31:2]] = mem_wr_data;
      end
      if (mem_rd_req) begin
        chk(mem_rd_addr[3:0] == 4'd0, "R4", "read address aligned", mem_rd_addr, {mem_rd_addr[31:4], 4'd0});
        for (int k = 0; k < 4; k++) fb[k] = mem_get({mem_rd_addr[31:4], 2'(k)});
        beats_out = 4;
        delay = 2;
        rd_count++;
        mem_rd_valid = 1'b0;
      end else if (beats_out > 0) begin
        if (delay > 0) begin
          delay--;
          mem_rd_valid = 1'b0;
        end else begin
          mem_rd_valid = 1'b1;
          mem_rd_data = fb[4 - beats_out];
          beats_out--;
          if (beats_out == 0) last_beat_cyc = cyc;
        end
      end else mem_rd_valid = 1'b0;
    end
  end

  task automatic do_op(input bit we, input logic [31:0] a, input logic [31:0] d, input string req);
    int lat, rd0, qsz;
    bit exp_miss;
    logic [31:0] exp;
    #1;
    qsz = exp_wq_a.size();
    rd0 = rd_count;
    exp = '0;
    exp_miss = 1'b0;
    if (!we) begin
      exp = ref_val.exists(a[31:2]) ? ref_val[a[31:2]] : init_word(a[31:2]);
      exp_miss = !(ref_tag.exists(a[15:4]) && ref_tag[a[15:4]] == a[31:16]);
    end else begin
      ref_val[a[31:2]] = d;
      exp_wq_a.push_back({a[31:2], 2'b00});
      exp_wq_d.push_back(d);
    end
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 1'b0;
    lat = 1;
    while (!cpu_done && lat < 4000) begin
      @(negedge clk);
      lat++;
    end
    last_lat = lat;
    if (lat >= 4000) chk(0, req, "request never completed", 32'(lat), 0);
    chk(!cpu_stall, "R10", "stall low with done", 32'(cpu_stall), 0);
    if (!we) begin
      chk(cpu_rdata == exp, req, "load data", cpu_rdata, exp);
      chk((rd_count != rd0) == exp_miss, "R1", "hit/miss decision", 32'(rd_count - rd0), 32'(exp_miss));
      if (exp_miss) begin
        chk(cyc == last_beat_cyc + 1, "R4", "done after last beat", 32'(cyc), 32'(last_beat_cyc + 1));
        ref_tag[a[15:4]] = a[31:16];
      end else chk(lat == 2, "R3", "hit latency", 32'(lat), 2);
    end else begin
      chk(rd_count == rd0, "R6", "store issued a read", 32'(rd_count - rd0), 0);
      if (qsz < 4) chk(lat == 2, "R7", "store latency with space", 32'(lat), 2);
    end
  endtask

  task automatic drain_all();
    for (int k = 0; k < 500 && exp_wq_a.size() != 0; k++) @(negedge clk);
    chk(exp_wq_a.size() == 0, "R5", "buffer drained", 32'(exp_wq_a.size()), 0);
  endtask

  initial begin : watchdog
    #200000;
    chk(0, "R10", "watchdog expired", 32'(cyc), 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!cpu_stall && !cpu_done, "R2", "idle processor side", {cpu_stall, cpu_done}, 0);
    chk(!mem_rd_req && !mem_wr_valid, "R2", "idle memory side", {mem_rd_req, mem_wr_valid}, 0);

    do_op(0, 32'h0000_1004, 0, "R2");      // first touch misses
    do_op(0, 32'h0000_1008, 0, "R4");      // rest of line now hits
    do_op(0, 32'h0000_100C, 0, "R3");
    do_op(0, 32'h0001_1000, 0, "R1");      // same index, new tag
    do_op(0, 32'h0000_1004, 0, "R1");      // evicted again

    do_op(1, 32'h0000_1008, 32'hCAFE_0001, "R6");  // store hit
    drain_all();
    do_op(0, 32'h0000_1008, 0, "R6");
    do_op(1, 32'h0002_0010, 32'hBEEF_0002, "R6");  // store miss, no allocate
    drain_all();
    do_op(0, 32'h0002_0010, 0, "R6");
    do_op(1, 32'h0003_0023, 32'h1234_5678, "R5");  // byte offset ignored
    drain_all();
    do_op(0, 32'h0003_0020, 0, "R5");

    // Held writes overlap a refill of the same line.
    wr_ctl = 1'b0;
    do_op(1, 32'h0004_0048, 32'hD1D1_D1D1, "R8");
    do_op(1, 32'h0004_0048, 32'hD2D2_D2D2, "R8");
    do_op(0, 32'h0004_0048, 0, "R8");      // miss, newest queued wins
    do_op(0, 32'h0004_004C, 0, "R8");
    do_op(1, 32'h0004_0040, 32'hD3D3_D3D3, "R7");
    do_op(1, 32'h0005_0000, 32'h0000_0004, "R7");   // fourth entry
    fork
      do_op(1, 32'h0005_0004, 32'h0000_0005, "R7"); // buffer full
      begin
        repeat (10) @(negedge clk);
        wr_ctl = 1'b1;
      end
    join
    chk(last_lat >= 11, "R7", "full buffer stall", 32'(last_lat), 11);
    do_op(0, 32'h0004_0040, 0, "R6");
    do_op(0, 32'h0004_0048, 0, "R8");

    for (int n = 0; n < 80; n++) begin
      logic [31:0] a;
      logic [31:0] bases [4];
      bases[0] = 32'h0000_1000; bases[1] = 32'h0001_1000;
      bases[2] = 32'h0002_1000; bases[3] = 32'h0000_2000;
      a = bases[rng[5:4]] + {rng[9:8], 2'b00};
      do_op(rng[2] & rng[7], a, {16'h7700, 16'(n)}, "R8");
    end
    drain_all();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule